// File: doc/BRIEF.md
# Graceful Stop and Poll Controller

This block sits beside the control register of an Ethernet DMA engine. Software writes the register to request that receive or transmit activity stop cleanly. If the direction is idle, the block reports completion on the next cycle. If a frame is moving, the request is held until that frame's end-of-frame pulse and completion is reported then. Each completion is a one-cycle event pulse. A one-cycle error interrupt request goes with it when the matching interrupt enable is set.

The same register also carries a wait-on-poll flag. Any write that leaves this flag clear restarts a periodic poll timer from zero. Each time the timer expires, the block issues a one-cycle strobe that tells the transmit engine to scan descriptor ring 0. The strobe is suppressed while transmit stop is set. If wait-on-poll is found set at an expiry, the timer stops and stays idle until the next write that clears the flag. The poll period is derived from the clock frequency and the poll rate, which defaults to 100 Hz.

Top module: `gstop_poll_ctrl`

## Requirements
- R1: After reset, all outputs are low and the poll timer is idle: no ring walk strobe appears until a control write with the wait-on-poll bit clear.
- R2: Control bit 0 requests receive stop. A write with bit 0 set while `rx_busy` is low produces a one-cycle `rx_stop_done` pulse in the cycle after the write.
- R3: A write with bit 0 set while `rx_busy` is high produces no pulse until `rx_eof`. `rx_stop_done` then pulses in the cycle after the `rx_eof` cycle. The pending request is then cleared, so a later `rx_eof` produces no pulse.
- R4: Control bit 1 requests transmit stop and follows the same immediate and deferred rules, using `tx_busy` and `tx_eof`, with the result on `tx_stop_done`.
- R5: `irq_mask` bit 0 enables the receive completion and bit 1 enables the transmit completion. `err_irq` pulses in the same cycle as a completion pulse only if that completion's enable is set.
- R6: Control bit 2 is wait-on-poll. A write with bit 2 clear starts the poll timer from zero, or restarts it if it is already running. `ring0_walk` pulses for one cycle exactly POLL_CYCLES cycles after that write, where POLL_CYCLES = CLK_HZ / POLL_HZ.
- R7: While wait-on-poll stays clear, the timer rearms at each expiry, giving a `ring0_walk` pulse every POLL_CYCLES cycles.
- R8: While the stored transmit stop bit (bit 1) is set, expiries produce no `ring0_walk`, but the timer keeps rearming.
- R9: If wait-on-poll is set at an expiry, no strobe is issued and the timer stops. A write with bit 2 set does not restart the timer.
- R10: A write with bits 0 and 1 clear produces no completion pulse and no `err_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Write data: bit 0 receive stop, bit 1 transmit stop, bit 2 wait-on-poll |
| rx_busy | input | 1 | A receive frame is in progress |
| tx_busy | input | 1 | A transmit frame is in progress |
| rx_eof | input | 1 | End of the current receive frame, one cycle |
| tx_eof | input | 1 | End of the current transmit frame, one cycle |
| irq_mask | input | 2 | Completion interrupt enables: bit 0 receive, bit 1 transmit |
| rx_stop_done | output | 1 | Receive stop complete event pulse |
| tx_stop_done | output | 1 | Transmit stop complete event pulse |
| err_irq | output | 1 | Error interrupt request pulse |
| ring0_walk | output | 1 | Strobe to scan transmit ring 0 |

## Verification
The assertions assume that `rx_eof` and `tx_eof` are single-cycle pulses, each marking the end of a frame that `rx_busy` or `tx_busy` announced. They also assume `irq_mask` holds steady across a completion. The stimulus drives every input on the falling clock edge. It raises an end-of-frame pulse only after the matching busy flag has been high, drops busy afterwards, and changes the mask only between scenarios. Stop scenarios keep wait-on-poll set in every write, so the timer stays idle until the poll scenarios begin.

// File: rtl/gspc_pkg.sv
package gspc_pkg;
  localparam int CTL_W         = 3;
  localparam int RX_STOP_BIT   = 0;
  localparam int TX_STOP_BIT   = 1;
  localparam int POLL_HOLD_BIT = 2;
  localparam int NDIR          = 2;
  localparam int DIR_RX        = 0;
  localparam int DIR_TX        = 1;
endpackage

// File: rtl/gspc_stop_unit.sv
module gspc_stop_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic req,
  input  logic busy,
  input  logic eof,
  output logic fire,
  output logic done
);
  logic pend_q, pend_d;
  logic done_q;

  always_comb begin
    fire   = (wr && req && !busy) || (pend_q && eof);
    pend_d = pend_q;
    if (fire) pend_d = 1'b0;
    if (wr && req && busy) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= fire;
    end
  end

  assign done = done_q;

  // R3
  deferred_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && eof) |=> done_q);

  // R2
  immediate_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req && !busy) |=> done_q);

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !eof) |=> pend_q);
endmodule

// File: rtl/gspc_poll_timer.sv
module gspc_poll_timer #(
  parameter int POLL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hold,
  input  logic tx_stopped,
  output logic walk
);
  localparam int CW = (POLL_CYCLES > 2) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          walk_q, walk_d;
  logic          expire;

  always_comb begin
    expire = run_q && (cnt_q == LAST);
    run_d  = run_q;
    cnt_d  = cnt_q;
    walk_d = 1'b0;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      if (expire) begin
        cnt_d = '0;
        if (!hold) begin
          walk_d = !tx_stopped;
        end else begin
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      walk_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      walk_q <= walk_d;
    end
  end

  assign walk = walk_q;

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < POLL_CYCLES);

  // R9
  hold_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && hold && !start) |=> (!run_q && !walk_q));

  // R8
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && tx_stopped && !start) |=> !walk_q);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> !walk_q);
endmodule

// File: rtl/gspc_irq_merge.sv
module gspc_irq_merge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  input  logic [N-1:0] enable,
  output logic         irq
);
  logic irq_q, irq_d;

  always_comb irq_d = |(fire & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/gstop_poll_ctrl.sv
module gstop_poll_ctrl #(
  parameter int CLK_HZ  = 250_000_000,
  parameter int POLL_HZ = 100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_wr,
  input  logic [gspc_pkg::CTL_W-1:0] ctl_wdata,
  input  logic                       rx_busy,
  input  logic                       tx_busy,
  input  logic                       rx_eof,
  input  logic                       tx_eof,
  input  logic [1:0]                 irq_mask,
  output logic                       rx_stop_done,
  output logic                       tx_stop_done,
  output logic                       err_irq,
  output logic                       ring0_walk
);
  import gspc_pkg::*;

  localparam int POLL_CYCLES = CLK_HZ / POLL_HZ;

  logic [NDIR-1:0] busy_v, eof_v, fire_v, done_v;
  logic            gts_q, gts_d, hold_q, hold_d;
  logic            poll_start;

  assign busy_v[DIR_RX] = rx_busy;
  assign busy_v[DIR_TX] = tx_busy;
  assign eof_v[DIR_RX]  = rx_eof;
  assign eof_v[DIR_TX]  = tx_eof;

  // stored control bits used by the poll timer, clock-enabled by the write
  always_comb begin
    gts_d  = gts_q;
    hold_d = hold_q;
    if (ctl_wr) begin
      gts_d  = ctl_wdata[TX_STOP_BIT];
      hold_d = ctl_wdata[POLL_HOLD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gts_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      gts_q  <= gts_d;
      hold_q <= hold_d;
    end
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    gspc_stop_unit u_stop (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (ctl_wr),
      .req  (ctl_wdata[RX_STOP_BIT + d]),
      .busy (busy_v[d]),
      .eof  (eof_v[d]),
      .fire (fire_v[d]),
      .done (done_v[d])
    );
  end

  gspc_irq_merge #(.N(NDIR)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire_v),
    .enable(irq_mask),
    .irq   (err_irq)
  );

  assign poll_start = ctl_wr && !ctl_wdata[POLL_HOLD_BIT];

  gspc_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (poll_start),
    .hold      (hold_q),
    .tx_stopped(gts_q),
    .walk      (ring0_walk)
  );

  assign rx_stop_done = done_v[DIR_RX];
  assign tx_stop_done = done_v[DIR_TX];

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (rx_stop_done || tx_stop_done));

  // R10
  no_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[1:0] == 2'b00 && !rx_eof && !tx_eof)
      |=> (!rx_stop_done && !tx_stop_done && !err_irq));
endmodule

// File: tb/gstop_poll_ctrl_bench.sv
module gstop_poll_ctrl_bench;
  localparam int P = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [2:0] ctl_wdata;
  logic       rx_busy, tx_busy, rx_eof, tx_eof;
  logic [1:0] irq_mask;
  logic       rx_stop_done, tx_stop_done, err_irq, ring0_walk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gstop_poll_ctrl #(.CLK_HZ(P * 100), .POLL_HZ(100)) u_gstop_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .rx_busy(rx_busy), .tx_busy(tx_busy), .rx_eof(rx_eof), .tx_eof(tx_eof),
    .irq_mask(irq_mask), .rx_stop_done(rx_stop_done),
    .tx_stop_done(tx_stop_done), .err_irq(err_irq), .ring0_walk(ring0_walk)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // returns at the negedge after the write edge
  task automatic write_ctl(input logic [2:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = 3'b000;
  endtask

  task automatic quiet_walk(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ring0_walk) seen = 1'b1;
    end
    chk(seen, 1'b0, req);
  endtask

  task automatic gap_walk(input int gap, input string req);
    int cnt = 0;
    for (int i = 1; i <= 3 * P; i++) begin
      @(negedge clk);
      if (ring0_walk) begin cnt = i; break; end
    end
    checks++;
    if (cnt != gap) begin
      errors++;
      $display("FAIL %s walk gap actual=%0d expected=%0d", req, cnt, gap);
    end
  endtask

  task automatic t_reset();
    chk(rx_stop_done, 1'b0, "R1 rx_stop_done");
    chk(tx_stop_done, 1'b0, "R1 tx_stop_done");
    chk(err_irq, 1'b0, "R1 err_irq");
    quiet_walk(3 * P, "R1 idle timer");
  endtask

  task automatic t_rx_now();
    irq_mask = 2'b01;
    write_ctl(3'b101);
    chk(rx_stop_done, 1'b1, "R2 rx immediate");
    chk(err_irq, 1'b1, "R5 rx enabled irq");
    chk(tx_stop_done, 1'b0, "R2 tx untouched");
    @(negedge clk);
    chk(rx_stop_done, 1'b0, "R2 single pulse");
    irq_mask = 2'b00;
    write_ctl(3'b101);
    chk(rx_stop_done, 1'b1, "R2 rx immediate again");
    chk(err_irq, 1'b0, "R5 rx masked irq");
  endtask

  task automatic t_rx_deferred();
    irq_mask = 2'b01;
    rx_busy = 1'b1;
    write_ctl(3'b101);
    chk(rx_stop_done, 1'b0, "R3 no pulse while busy");
    repeat (3) @(negedge clk);
    chk(rx_stop_done, 1'b0, "R3 still waiting");
    rx_eof = 1'b1;
    @(negedge clk);
    rx_eof = 1'b0; rx_busy = 1'b0;
    chk(rx_stop_done, 1'b1, "R3 done after eof");
    chk(err_irq, 1'b1, "R5 deferred irq");
    @(negedge clk);
    chk(rx_stop_done, 1'b0, "R3 single pulse");
    rx_busy = 1'b1; rx_eof = 1'b1;
    @(negedge clk);
    rx_eof = 1'b0; rx_busy = 1'b0;
    chk(rx_stop_done, 1'b0, "R3 pending cleared");
  endtask

  task automatic t_tx();
    irq_mask = 2'b10;
    write_ctl(3'b110);
    chk(tx_stop_done, 1'b1, "R4 tx immediate");
    chk(err_irq, 1'b1, "R5 tx enabled irq");
    irq_mask = 2'b01;
    tx_busy = 1'b1;
    write_ctl(3'b110);
    chk(tx_stop_done, 1'b0, "R4 tx deferred wait");
    tx_eof = 1'b1;
    @(negedge clk);
    tx_eof = 1'b0; tx_busy = 1'b0;
    chk(tx_stop_done, 1'b1, "R4 tx done after eof");
    chk(err_irq, 1'b0, "R5 tx masked by rx enable");
  endtask

  task automatic t_no_req();
    irq_mask = 2'b11;
    write_ctl(3'b100);
    chk(rx_stop_done, 1'b0, "R10 no rx pulse");
    chk(tx_stop_done, 1'b0, "R10 no tx pulse");
    chk(err_irq, 1'b0, "R10 no irq");
    quiet_walk(2 * P, "R9 hold write does not start timer");
  endtask

  task automatic t_poll();
    write_ctl(3'b000);
    gap_walk(P, "R6 first walk");
    @(negedge clk);
    chk(ring0_walk, 1'b0, "R6 walk single cycle");
    gap_walk(P - 1, "R7 rearm");
    gap_walk(P, "R7 rearm again");
    repeat (P / 2) @(negedge clk);
    write_ctl(3'b000);
    gap_walk(P, "R6 restart");
  endtask

  task automatic t_gated();
    write_ctl(3'b010);
    chk(tx_stop_done, 1'b1, "R4 tx stop with poll");
    quiet_walk(3 * P, "R8 walks suppressed");
    write_ctl(3'b100);
    quiet_walk(3 * P, "R9 hold stops timer");
    write_ctl(3'b000);
    gap_walk(P, "R6 start from idle");
    repeat (2) @(negedge clk);
    write_ctl(3'b100);
    quiet_walk(3 * P, "R9 hold at expiry");
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = 3'b000;
    rx_busy = 1'b0; tx_busy = 1'b0; rx_eof = 1'b0; tx_eof = 1'b0;
    irq_mask = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_now();
    t_rx_deferred();
    t_tx();
    t_no_req();
    t_poll();
    t_gated();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule